// File: doc/BRIEF.md
# Shared Grant / Interrupt-Acknowledge Chain Node

This block is the per-device node for a pair of daisy-chain lines, one incoming grant and one outgoing grant, on a multidrop extension bus. Most of the time the pair is the bus-arbitration grant chain: the node either keeps an arriving grant for a local bus request or hands it on downstream. While an interrupt-acknowledge cycle runs on the bus, with address-modifier code 0x12, the same pair becomes the interrupt-acknowledge chain. Several devices may share one interrupt line, and the chain decides which one answers.

In acknowledge mode a node that has no pending interrupt at the level being acknowledged hands the acknowledge on. A node with a matching pending interrupt keeps it and raises a claim, together with its level. That claim is the request to turn the bus cycle into a backplane IACK cycle. The backplane cycle is run elsewhere. A node configured as the system controller does not wait for an incoming grant. It starts the acknowledge chain as soon as it sees the acknowledge code on an active cycle.

Top module: `chain_grant_node`

## Requirements
- R1: After a synchronous active-low reset, `grant_out`, `arb_won`, `iack_claim` and `claim_level` are all 0. Reset applied mid-cycle clears a held claim on the next clock.
- R2: In arbitration mode, a grant arriving with no local request appears on `grant_out` one clock later. `grant_out` falls one clock after `grant_in` falls.
- R3: In arbitration mode, a grant arriving while `arb_req` is high sets `arb_won` one clock later and is not passed on. The decision holds until `grant_in` falls, even if `arb_req` drops first.
- R4: Acknowledge mode is in force only while `cyc_active` is 1 and `am_code` equals 0x12. Any other code, or no active cycle, leaves the lines in arbitration mode, including straight after an acknowledge cycle ends.
- R5: In acknowledge mode, an ordinary node with no pending interrupt drives `grant_out` high one clock after `grant_in` rises.
- R6: In acknowledge mode, a node whose `irq_pending` is 1 and whose `irq_level` equals `ack_level` when the acknowledge arrives raises `iack_claim` one clock later, with `claim_level` equal to that level. It keeps `grant_out` low.
- R7: In acknowledge mode, a pending interrupt at a level other than `ack_level` does not claim. The acknowledge is forwarded.
- R8: With `cfg_sysctl` = 1 the node starts the acknowledge chain by itself, one clock after the cycle is seen, without `grant_in`. With `cfg_sysctl` = 0 nothing is forwarded until `grant_in` rises.
- R9: The pass/claim choice is made once per acknowledge cycle. An interrupt that becomes pending after the node has forwarded does not turn into a claim. A claim stays while the cycle lasts, even if `grant_in` falls, and clears one clock after the cycle ends.
- R10: `iack_claim` and `grant_out` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sysctl | input | 1 | 1: node is system controller and originates the acknowledge chain |
| cyc_active | input | 1 | A bus cycle is in progress |
| am_code | input | 6 | Address-modifier code on the bus |
| ack_level | input | 3 | Interrupt level being acknowledged |
| grant_in | input | 1 | Incoming daisy-chain grant |
| arb_req | input | 1 | Local bus request for the arbitration chain |
| irq_pending | input | 1 | Local interrupt is pending |
| irq_level | input | 3 | Level of the local pending interrupt |
| grant_out | output | 1 | Outgoing daisy-chain grant |
| arb_won | output | 1 | Node kept the arbitration grant |
| iack_claim | output | 1 | Node kept the acknowledge; request for a backplane IACK cycle |
| claim_level | output | 3 | Level of the claimed interrupt, 0 when not claiming |

## Verification
A node whose stored decision is wrong shows it on the very next clock. A missing forward stalls every device downstream, because `grant_out` stays low. A spurious forward or claim shows up as `grant_out` and `iack_claim` both high, or as a claim with the wrong `claim_level`. If the claim or the forward is left set after the cycle ends, the outputs are still high one clock after `cyc_active` falls or `grant_in` drops. That is exactly the cycle the stimulus samples, so a stuck mode or decision register is caught within one clock of the event that should have cleared it.

// File: rtl/chain_node_pkg.sv
// Shared types for the grant/acknowledge chain node.
// Assumes: nothing beyond IEEE 1800-2017.
package chain_node_pkg;

    // Which function the shared chain lines currently carry.
    typedef enum logic {
        CH_ARB  = 1'b0,
        CH_IACK = 1'b1
    } chain_mode_e;

endpackage

// File: rtl/chain_mode_sel.sv
// Decodes whether the shared chain lines act as the acknowledge chain.
// Assumes: am_code and cyc_active are stable, synchronous bus samples.
module chain_mode_sel
    import chain_node_pkg::*;
#(
    parameter int          AM_W      = 6,
    parameter logic [AM_W-1:0] IACK_CODE = 6'h12
) (
    input  logic            cyc_active,
    input  logic [AM_W-1:0] am_code,
    output chain_mode_e     mode
);

    // Acknowledge mode only during an active cycle carrying the acknowledge code.
    always_comb begin
        mode = (cyc_active && (am_code == IACK_CODE)) ? CH_IACK : CH_ARB;
    end

endmodule

// File: rtl/iack_chain_stage.sv
// Pass/claim decision for the interrupt-acknowledge chain.
// Decides once per acknowledge cycle. A claim holds until the cycle ends.
// A forward drops one clock after the chain start input drops.
// Assumes: active is low between acknowledge cycles.
module iack_chain_stage #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             start,
    input  logic             irq_pending,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] ack_level,
    output logic             fwd,
    output logic             claim,
    output logic [LVL_W-1:0] claim_level
);

    logic decided_q;
    logic match;

    // A local interrupt matches when pending at the level being acknowledged.
    always_comb begin
        match = irq_pending && (irq_level == ack_level);
    end

    // Latch the one-time pass/claim decision and release it at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            fwd         <= 1'b0;
            claim       <= 1'b0;
            claim_level <= '0;
            decided_q   <= 1'b0;
        end else if (start) begin
            if (!decided_q) begin
                decided_q <= 1'b1;
                if (match) begin
                    claim       <= 1'b1;
                    claim_level <= irq_level;
                end else begin
                    fwd <= 1'b1;
                end
            end
        end else begin
            fwd <= 1'b0;
        end
    end

endmodule

// File: rtl/arb_chain_stage.sv
// Keep-or-pass decision for the arbitration grant chain.
// Decides once per grant pulse. The state is frozen while hold is high,
// so a bus owner running an acknowledge cycle keeps its grant.
// Assumes: grant_in is a clean synchronous level.
module arb_chain_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic grant_in,
    input  logic arb_req,
    output logic fwd,
    output logic won
);

    logic decided_q;

    // Track the grant: decide on arrival, clear when the grant leaves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd       <= 1'b0;
            won       <= 1'b0;
            decided_q <= 1'b0;
        end else if (!hold) begin
            if (!grant_in) begin
                fwd       <= 1'b0;
                won       <= 1'b0;
                decided_q <= 1'b0;
            end else if (!decided_q) begin
                decided_q <= 1'b1;
                if (arb_req) begin
                    won <= 1'b1;
                end else begin
                    fwd <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/chain_grant_node.sv
// Per-device node on a shared grant/acknowledge daisy chain.
// The address-modifier decode picks the meaning of the chain lines. The
// acknowledge stage or the arbitration stage then drives grant_out.
// Assumes: synchronous bus inputs; the backplane acknowledge cycle itself
// is run by logic outside this block, triggered by iack_claim.
module chain_grant_node
    import chain_node_pkg::*;
#(
    parameter int              AM_W      = 6,
    parameter int              LVL_W     = 3,
    parameter logic [AM_W-1:0] IACK_CODE = 6'h12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sysctl,
    input  logic             cyc_active,
    input  logic [AM_W-1:0]  am_code,
    input  logic [LVL_W-1:0] ack_level,
    input  logic             grant_in,
    input  logic             arb_req,
    input  logic             irq_pending,
    input  logic [LVL_W-1:0] irq_level,
    output logic             grant_out,
    output logic             arb_won,
    output logic             iack_claim,
    output logic [LVL_W-1:0] claim_level
);

    chain_mode_e mode_now;
    chain_mode_e mode_q;
    logic        iack_active;
    logic        iack_start;
    logic        iack_fwd;
    logic        arb_fwd;

    chain_mode_sel #(
        .AM_W      (AM_W),
        .IACK_CODE (IACK_CODE)
    ) u_mode (
        .cyc_active (cyc_active),
        .am_code    (am_code),
        .mode       (mode_now)
    );

    // Acknowledge activity and chain origin: the system controller starts it.
    always_comb begin
        iack_active = (mode_now == CH_IACK);
        iack_start  = cfg_sysctl ? 1'b1 : grant_in;
    end

    iack_chain_stage #(
        .LVL_W (LVL_W)
    ) u_iack (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (iack_active),
        .start       (iack_start),
        .irq_pending (irq_pending),
        .irq_level   (irq_level),
        .ack_level   (ack_level),
        .fwd         (iack_fwd),
        .claim       (iack_claim),
        .claim_level (claim_level)
    );

    arb_chain_stage u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (iack_active),
        .grant_in (grant_in),
        .arb_req  (arb_req),
        .fwd      (arb_fwd),
        .won      (arb_won)
    );

    // Register the mode so the output select moves with the stage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= CH_ARB;
        end else begin
            mode_q <= mode_now;
        end
    end

    // Drive the outgoing chain line from the stage owning it this cycle.
    always_comb begin
        grant_out = (mode_q == CH_IACK) ? iack_fwd : arb_fwd;
    end

endmodule

// File: rtl/chain_grant_node_chk.sv
// Property checker for chain_grant_node, attached through bind.
// Assumes: same parameters as the checked instance.
module chain_grant_node_chk #(
    parameter int              AM_W      = 6,
    parameter int              LVL_W     = 3,
    parameter logic [AM_W-1:0] IACK_CODE = 6'h12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_sysctl,
    input logic             cyc_active,
    input logic [AM_W-1:0]  am_code,
    input logic [LVL_W-1:0] ack_level,
    input logic             grant_in,
    input logic             arb_req,
    input logic             irq_pending,
    input logic [LVL_W-1:0] irq_level,
    input logic             grant_out,
    input logic             arb_won,
    input logic             iack_claim,
    input logic [LVL_W-1:0] claim_level
);

    AST_CLAIM_XOR_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack_claim && grant_out)); // R10

    AST_FWD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_in && !cfg_sysctl) |=> !grant_out); // R2

    AST_CLAIM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_active && am_code == IACK_CODE) |=> !iack_claim); // R9

    AST_CLAIM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_claim) |-> ($past(irq_pending) && claim_level == $past(irq_level)
                               && claim_level == $past(ack_level))); // R6

    AST_WON_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_won) |-> $past(arb_req)); // R3

    AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_claim |-> claim_level == '0); // R1

endmodule

bind chain_grant_node chain_grant_node_chk #(
    .AM_W      (AM_W),
    .LVL_W     (LVL_W),
    .IACK_CODE (IACK_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sysctl  (cfg_sysctl),
    .cyc_active  (cyc_active),
    .am_code     (am_code),
    .ack_level   (ack_level),
    .grant_in    (grant_in),
    .arb_req     (arb_req),
    .irq_pending (irq_pending),
    .irq_level   (irq_level),
    .grant_out   (grant_out),
    .arb_won     (arb_won),
    .iack_claim  (iack_claim),
    .claim_level (claim_level)
);

// File: tb/chain_grant_node_test.sv
module chain_grant_node_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sysctl = 1'b0;
    logic       cyc_active = 1'b0;
    logic [5:0] am_code = '0;
    logic [2:0] ack_level = '0;
    logic       grant_in = 1'b0;
    logic       arb_req = 1'b0;
    logic       irq_pending = 1'b0;
    logic [2:0] irq_level = '0;
    logic       grant_out;
    logic       arb_won;
    logic       iack_claim;
    logic [2:0] claim_level;

    int applied = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    chain_grant_node uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_sysctl  (cfg_sysctl),
        .cyc_active  (cyc_active),
        .am_code     (am_code),
        .ack_level   (ack_level),
        .grant_in    (grant_in),
        .arb_req     (arb_req),
        .irq_pending (irq_pending),
        .irq_level   (irq_level),
        .grant_out   (grant_out),
        .arb_won     (arb_won),
        .iack_claim  (iack_claim),
        .claim_level (claim_level)
    );

    // Vector: {sys, cyc, am[6], ack_lvl[3], gin, req, pend, plvl[3],
    //          exp gout, exp won, exp claim, exp clvl[3]}
    localparam int NV = 25;
    localparam logic [22:0] VEC [NV] = '{
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 0  R2 idle
        {1'b0,1'b0,6'h00,3'd0,1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,1'b0,3'd0}, // 1  R2 pass grant
        {1'b0,1'b0,6'h00,3'd0,1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,1'b0,3'd0}, // 2  R2 hold
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 3  R2 release
        {1'b0,1'b0,6'h00,3'd0,1'b1,1'b1,1'b0,3'd0, 1'b0,1'b1,1'b0,3'd0}, // 4  R3 keep grant
        {1'b0,1'b0,6'h00,3'd0,1'b1,1'b0,1'b0,3'd0, 1'b0,1'b1,1'b0,3'd0}, // 5  R3 decision held
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 6  R3 release
        {1'b0,1'b1,6'h09,3'd3,1'b1,1'b0,1'b1,3'd3, 1'b1,1'b0,1'b0,3'd0}, // 7  R4 other code
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 8  R4 idle
        {1'b0,1'b1,6'h12,3'd2,1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,1'b0,3'd0}, // 9  R5 forward
        {1'b0,1'b1,6'h12,3'd2,1'b1,1'b0,1'b1,3'd2, 1'b1,1'b0,1'b0,3'd0}, // 10 R9 late irq
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 11 R9 end
        {1'b0,1'b1,6'h12,3'd5,1'b1,1'b0,1'b1,3'd5, 1'b0,1'b0,1'b1,3'd5}, // 12 R6 claim
        {1'b0,1'b1,6'h12,3'd5,1'b0,1'b0,1'b1,3'd5, 1'b0,1'b0,1'b1,3'd5}, // 13 R9 claim held
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 14 R9 claim clears
        {1'b0,1'b1,6'h12,3'd4,1'b1,1'b0,1'b1,3'd6, 1'b1,1'b0,1'b0,3'd0}, // 15 R7 mismatch
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 16 R7 end
        {1'b1,1'b1,6'h12,3'd1,1'b0,1'b0,1'b0,3'd0, 1'b1,1'b0,1'b0,3'd0}, // 17 R8 origin
        {1'b1,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 18 R8 end
        {1'b1,1'b1,6'h12,3'd7,1'b0,1'b0,1'b1,3'd7, 1'b0,1'b0,1'b1,3'd7}, // 19 R8 self claim
        {1'b1,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 20 R8 end
        {1'b0,1'b1,6'h12,3'd3,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}, // 21 R8 no origin
        {1'b0,1'b1,6'h12,3'd3,1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,1'b0,3'd0}, // 22 R5 forward
        {1'b0,1'b0,6'h00,3'd0,1'b1,1'b0,1'b0,3'd0, 1'b1,1'b0,1'b0,3'd0}, // 23 R4 back to arb
        {1'b0,1'b0,6'h00,3'd0,1'b0,1'b0,1'b0,3'd0, 1'b0,1'b0,1'b0,3'd0}  // 24 R2 release
    };
    localparam int TAG [NV] = '{2,2,2,2,3,3,3,4,4,5,9,9,6,9,9,7,7,8,8,8,8,8,5,4,2};

    task automatic check(input int tag, input logic [5:0] act, input logic [5:0] exp);
        applied++;
        if (act !== exp || (act[5] && act[3])) begin
            misses++;
            $display("FAIL R%0d: {gout,won,claim,lvl} actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, {grant_out, arb_won, iack_claim, claim_level}, 6'b0); // R1 in reset
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at negedge, sample 1 ns after the capturing edge.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {cfg_sysctl, cyc_active, am_code, ack_level, grant_in, arb_req,
             irq_pending, irq_level} = VEC[i][22:6];
            @(posedge clk);
            #1;
            check(TAG[i], {grant_out, arb_won, iack_claim, claim_level}, VEC[i][5:0]);
        end

        // R1: reset in the middle of a held claim clears it on the next clock.
        @(negedge clk);
        cyc_active = 1'b1; am_code = 6'h12; ack_level = 3'd6;
        grant_in = 1'b1; irq_pending = 1'b1; irq_level = 3'd6;
        @(posedge clk);
        #1;
        check(6, {grant_out, arb_won, iack_claim, claim_level}, 6'b001110); // R6
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(1, {grant_out, arb_won, iack_claim, claim_level}, 6'b0); // R1
        @(negedge clk);
        rst_n = 1'b1; grant_in = 1'b0;
        @(posedge clk);
        #1;
        check(8, {grant_out, arb_won, iack_claim, claim_level}, 6'b0); // R8 no origin without grant
        @(negedge clk);
        cyc_active = 1'b0; irq_pending = 1'b0;
        @(posedge clk);
        #1;
        check(9, {grant_out, arb_won, iack_claim, claim_level}, 6'b0); // R9 cycle over

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

endmodule